// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block produces the next four expanded message words of the SM3 hash schedule. It does the work in two partial steps, each a single pass through the datapath. An operation-select input picks the step. Every pass takes three 128-bit operands and returns one 128-bit result. Each operand and the result carry four 32-bit lanes.

The pre-pass mixes older schedule words with XOR and a rotate, then applies the P1 permutation to each lane. The finishing pass combines the pre-pass output with rotated and plain earlier words. Its top lane also folds in rotated copies of the new word that lands in lane 0.

A valid/ready handshake sits on both sides, with one output register stage between them. A word presented on a transfer appears at the output one cycle later. The stage can take a new transfer in the same cycle that the held result is drained.

Top module: `msgexp_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_step`=0, for lane j in 0..2 (lane j is bits [32j+31:32j] of every vector), the result lane is P1(t). Here t = `opa`[j] ^ `opc`[j] ^ rotl(`opb`[j],15).
- R3: With `in_step`=0, result lane 3 is P1(`opa`[3] ^ `opc`[3]), and `opb` lane 3 has no effect on any result lane.
- R4: P1(x) = x ^ rotl(x,15) ^ rotl(x,23), where rotl is a 32-bit rotate left.
- R5: With `in_step`=1, for lane j in 0..2, result lane j = rotl(`opb`[j],7) ^ `opc`[j] ^ `opa`[j].
- R6: With `in_step`=1, let u = rotl(`opb`[3],7) ^ `opc`[3] ^ `opa`[3], and let n0 be result lane 0. Result lane 3 is u ^ rotl(n0,6) ^ rotl(n0,15) ^ rotl(n0,30).
- R7: `in_step` and the operands are captured on the edge where `in_valid` and `in_ready` are both 1. The result is valid from that edge on, and later changes to the inputs do not alter it.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold, and `in_ready` is 0.
- R9: When `out_valid` and `out_ready` are both 1, `in_ready` is 1, so a new transfer is accepted in the same cycle the old result drains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and select are presented |
| in_ready | output | 1 | Stage can take a transfer |
| in_step | input | 1 | 0 = pre-pass, 1 = finishing pass |
| opa | input | 128 | First operand, four 32-bit lanes |
| opb | input | 128 | Second operand, four 32-bit lanes |
| opc | input | 128 | Third operand, four 32-bit lanes |
| out_valid | output | 1 | Result register holds a word |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Four result lanes |

## Verification
A fault in a lane's datapath shows up on `out_data` exactly one cycle after the transfer that uses it. The bench sweeps single set bits through every operand bit in both passes, so a wrong rotate amount or a wrong lane mapping changes a specific lane at a specific bit. An error in the lane-0 fold of the finishing pass appears only in lane 3, at the same point in time. A wrong full/empty state shows at the ports within a cycle: `in_ready` is wrong during a stall, or a result is lost or duplicated across a back-to-back transfer.

// File: rtl/msgexp_pkg.sv
package msgexp_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned VEC_W  = LANE_W * LANES;

  // rotate amounts used by the two passes
  localparam int unsigned PRE_ROT  = 15;
  localparam int unsigned P1_ROT_A = 15;
  localparam int unsigned P1_ROT_B = 23;
  localparam int unsigned FIN_ROT  = 7;
  localparam int unsigned FIX_A    = 6;
  localparam int unsigned FIX_B    = 15;
  localparam int unsigned FIX_C    = 30;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [VEC_W-1:0]  vec_t;

  typedef enum logic {
    OP_PRE = 1'b0,
    OP_FIN = 1'b1
  } op_e;

  function automatic lane_t rotl(input lane_t x, input int unsigned n);
    return (x << n) | (x >> (LANE_W - n));
  endfunction

  function automatic lane_t perm_p1(input lane_t x);
    return x ^ rotl(x, P1_ROT_A) ^ rotl(x, P1_ROT_B);
  endfunction

  function automatic lane_t lane0_fold(input lane_t w);
    return rotl(w, FIX_A) ^ rotl(w, FIX_B) ^ rotl(w, FIX_C);
  endfunction
endpackage

// File: rtl/msgexp_pre.sv
module msgexp_pre
  import msgexp_pkg::*;
(
  input  vec_t mid_w,
  input  vec_t near_w,
  input  vec_t far_w,
  output vec_t res
);
  lane_t unused_near_top;
  assign unused_near_top = near_w[VEC_W-1 -: LANE_W];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    lane_t tmp;
    if (j < LANES - 1) begin : g_rot
      assign tmp = mid_w[j*LANE_W +: LANE_W] ^ far_w[j*LANE_W +: LANE_W]
                 ^ rotl(near_w[j*LANE_W +: LANE_W], PRE_ROT);
    end else begin : g_plain
      assign tmp = mid_w[j*LANE_W +: LANE_W] ^ far_w[j*LANE_W +: LANE_W];
    end
    assign res[j*LANE_W +: LANE_W] = perm_p1(tmp);
  end
endmodule

// File: rtl/msgexp_fin.sv
module msgexp_fin
  import msgexp_pkg::*;
(
  input  vec_t part_w,
  input  vec_t old_w,
  input  vec_t mid_w,
  output vec_t res
);
  lane_t base [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign base[j] = rotl(old_w[j*LANE_W +: LANE_W], FIN_ROT)
                   ^ mid_w[j*LANE_W +: LANE_W] ^ part_w[j*LANE_W +: LANE_W];
    if (j == LANES - 1) begin : g_top
      assign res[j*LANE_W +: LANE_W] = base[j] ^ lane0_fold(base[0]);
    end else begin : g_low
      assign res[j*LANE_W +: LANE_W] = base[j];
    end
  end
endmodule

// File: rtl/msgexp_hold_reg.sv
module msgexp_hold_reg #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      if (load) begin
        full <= 1'b1;
        q    <= d;
      end else if (drain) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msgexp_unit.sv
module msgexp_unit
  import msgexp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_step,
  input  logic [127:0] opa,
  input  logic [127:0] opb,
  input  logic [127:0] opc,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data
);
  vec_t pre_res, fin_res, next_res;
  logic accept_evt, drain_evt;

  msgexp_pre u_pre (
    .mid_w (opa),
    .near_w(opb),
    .far_w (opc),
    .res   (pre_res)
  );

  msgexp_fin u_fin (
    .part_w(opa),
    .old_w (opb),
    .mid_w (opc),
    .res   (fin_res)
  );

  assign next_res   = (op_e'(in_step) == OP_FIN) ? fin_res : pre_res;
  assign in_ready   = !out_valid || out_ready;
  assign accept_evt = in_valid && in_ready;
  assign drain_evt  = out_valid && out_ready;

  msgexp_hold_reg #(.WIDTH(VEC_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept_evt),
    .drain(drain_evt),
    .d    (next_res),
    .q    (out_data),
    .full (out_valid)
  );
endmodule

module msgexp_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_data,
  input logic         accept_evt,
  input logic         drain_evt
);
  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> out_valid);

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && !in_valid) |=> !out_valid);

  // R9
  drain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt |-> in_ready);
endmodule

bind msgexp_unit msgexp_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .accept_evt(accept_evt),
  .drain_evt (drain_evt)
);

// File: tb/tb_msgexp_unit.sv
module tb_msgexp_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_step = 1'b0;
  logic [127:0] opa = '0, opb = '0, opc = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msgexp_unit dut (.*);

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] lane(input logic [127:0] v, input int j);
    return v[32*j +: 32];
  endfunction

  function automatic logic [31:0] p1m(input logic [31:0] x);
    return x ^ rl(x, 15) ^ rl(x, 23);
  endfunction

  function automatic logic [127:0] model(input bit step, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [31:0] r [4];
    if (!step) begin
      for (int j = 0; j < 3; j++)
        r[j] = p1m(lane(c, j) ^ lane(a, j) ^ rl(lane(b, j), 15));
      r[3] = p1m(lane(c, 3) ^ lane(a, 3));
    end else begin
      for (int j = 0; j < 4; j++)
        r[j] = lane(a, j) ^ lane(c, j) ^ rl(lane(b, j), 7);
      r[3] = r[3] ^ rl(r[0], 30) ^ rl(r[0], 15) ^ rl(r[0], 6);
    end
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_lanes(input bit step, input logic [127:0] exp);
    for (int j = 0; j < 4; j++) begin
      string tag;
      if (!step) tag = (j == 3) ? "R3 R4 pre lane3" : "R2 R4 pre lane";
      else       tag = (j == 3) ? "R6 fin lane3" : "R5 fin lane";
      chk(lane(out_data, j) == lane(exp, j), tag, {96'd0, lane(out_data, j)},
          {96'd0, lane(exp, j)});
    end
  endtask

  task automatic xfer(input bit step, input logic [127:0] a, input logic [127:0] b,
                      input logic [127:0] c);
    logic [127:0] exp;
    exp = model(step, a, b, c);
    @(negedge clk);
    in_valid = 1'b1; in_step = step; opa = a; opb = b; opc = c; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R7 valid after transfer", {127'd0, out_valid}, 128'd1);
    chk_lanes(step, exp);
  endtask

  logic [63:0] seed = 64'h9E3779B97F4A7C15;
  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    for (int k = 0; k < 2; k++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 7);
      seed = seed ^ (seed << 17);
      v[64*k +: 64] = seed;
    end
    return v;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] ea, eb, a1, b1, c1, a2, b2, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1 out_valid after reset", {127'd0, out_valid}, 128'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", {127'd0, in_ready}, 128'd1);

    // walking single set bit through each operand, both passes (R2 R3 R5 R6)
    for (int s = 0; s < 2; s++)
      for (int op = 0; op < 3; op++)
        for (int bt = 0; bt < 128; bt++) begin
          logic [127:0] v;
          v = 128'd1 << bt;
          xfer(s[0], (op == 0) ? v : 128'd0, (op == 1) ? v : 128'd0,
               (op == 2) ? v : 128'd0);
        end

    // dense random operands
    for (int k = 0; k < 300; k++) begin
      a1 = rnd128(); b1 = rnd128(); c1 = rnd128();
      xfer(k[0], a1, b1, c1);
    end

    // R3: top lane of second operand ignored in pre-pass
    a1 = rnd128(); b1 = rnd128(); c1 = rnd128();
    b1[127:96] = 32'd0;
    ea = model(1'b0, a1, b1, c1);
    b1[127:96] = 32'hFFFF_FFFF;
    @(negedge clk);
    in_valid = 1'b1; in_step = 1'b0; opa = a1; opb = b1; opc = c1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data == ea, "R3 opb lane3 ignored", out_data, ea);

    // R9: back-to-back transfers while draining
    a1 = rnd128(); b1 = rnd128(); c1 = rnd128();
    a2 = rnd128(); b2 = rnd128(); c2 = rnd128();
    ea = model(1'b1, a1, b1, c1);
    eb = model(1'b0, a2, b2, c2);
    @(negedge clk);
    in_valid = 1'b1; in_step = 1'b1; opa = a1; opb = b1; opc = c1; out_ready = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready while draining", {127'd0, in_ready}, 128'd1);
    chk(out_data == ea, "R9 first word", out_data, ea);
    in_step = 1'b0; opa = a2; opb = b2; opc = c2;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 second valid", {127'd0, out_valid}, 128'd1);
    chk(out_data == eb, "R9 second word", out_data, eb);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 empty after drain", {127'd0, out_valid}, 128'd0);

    // R8 / R7: stall holds data; later input changes do not alter it
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_step = 1'b0; opa = a1; opb = b1; opc = c1;
    ea = model(1'b0, a1, b1, c1);
    eb = model(1'b1, a2, b2, c2);
    @(negedge clk);
    in_step = 1'b1; opa = a2; opb = b2; opc = c2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held", {127'd0, out_valid}, 128'd1);
      chk(in_ready == 1'b0, "R8 ready low in stall", {127'd0, in_ready}, 128'd0);
      chk(out_data == ea, "R7 R8 data held", out_data, ea);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data == eb, "R8 R9 next word after release", out_data, eb);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule